// File: doc/BRIEF.md
# Serial NOR Program and Sector-Erase Sequencer

This block takes one high-level request, either "program N bytes starting at a 24-bit address" or "erase the 4 KB sector at an address", and produces the complete serial NOR command traffic for it. The traffic is issued one byte at a time through a byte transfer port. The block also drives chip-select through two separate one-cycle controls: one to assert it and one to release it. The block wraps every operation in a write-enable step and a closing write-disable step. It polls the flash status register after each command that changes state, and it reports completion with a single done pulse.

Program data arrives on a streaming byte input with valid/ready flow control, and each accepted byte becomes exactly one transfer. When the running address crosses a 256-byte page while bytes remain, the sequencer closes the page program on its own. It then waits for the flash to go idle, enables writes again and restarts the program command at the new address. The host supplies no help for this. Status polling sends the read-status opcode once and then reads status bytes with chip-select held, until the required bit pattern appears. There is no timeout.

Top module: `fseq_ctrl`

## Requirements
- R1: After reset the block is idle: req_ready_o is 1, and done_o, xfer_valid_o, cs_assert_o and cs_release_o are 0.
- R2: A request is taken only when req_valid_i and req_ready_o are both 1. req_ready_o stays 0 from the acceptance until done_o has pulsed, and a request presented during that time has no effect on the transfer stream.
- R3: Every operation opens with a chip-select assert, the byte 0x06 and a release. A status poll follows that waits for bit 0 (busy) to be 0 and bit 1 (write-enable latch) to be 1.
- R4: A program sends a chip-select assert, the opcode 0x02 and then the 24-bit address, with bits 23:16 first, 15:8 next and 7:0 last.
- R5: An erase sends a chip-select assert, the opcode 0x20 and the 3 address bytes in the same order, then a release. It takes no byte from the data stream, and req_len_i is ignored.
- R6: Program data bytes are taken from wdata_i in order, one per transfer. No data transfer is offered while wdata_valid_i is 0, and exactly req_len_i bytes are consumed.
- R7: When a data byte sent at an address whose low 8 bits are 0xFF is not the last byte, the block releases chip-select and polls until busy is 0. It then repeats the write-enable step of R3 and sends a new program header for the next address, with the address wrapping at 24 bits. A program whose final byte lands at offset 0xFF gets no restart.
- R8: After the last program byte, or after the erase address, chip-select is released and the status is polled until bit 0 is 0. Bit 1 is ignored in this poll.
- R9: After the operation poll, the block sends assert, 0x04, release, and then polls until bits 0 and 1 are both 0.
- R10: done_o is a one-cycle pulse in the cycle after the write-disable poll releases chip-select. req_ready_o is 1 in the cycle after done_o.
- R11: A status poll is: assert, the byte 0x05, then dummy bytes 0x00 whose returned byte is tested, repeated with chip-select held until the condition holds, then release.
- R12: cs_assert_o and cs_release_o never coincide with each other or with xfer_valid_o. Every transfer happens while chip-select is asserted. A non-data byte on offer holds its value until accepted.
- R13: A program with req_len_i equal to 0 sends the header and then goes straight to the R8 release and poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_erase_i | input | 1 | 1 selects sector erase, 0 selects program |
| req_addr_i | input | 24 | Start address of the operation |
| req_len_i | input | LEN_W | Byte count for a program |
| wdata_valid_i | input | 1 | Program byte available |
| wdata_ready_o | output | 1 | Program byte taken this cycle |
| wdata_i | input | 8 | Program byte |
| cs_assert_o | output | 1 | One-cycle pulse that asserts flash chip-select |
| cs_release_o | output | 1 | One-cycle pulse that releases flash chip-select |
| xfer_valid_o | output | 1 | A byte is offered for transfer |
| xfer_ready_i | input | 1 | Transfer completes this cycle |
| xfer_data_o | output | 8 | Byte to send |
| xfer_rdata_i | input | 8 | Byte returned by the completing transfer |
| done_o | output | 1 | One-cycle pulse when the operation finishes |

## Verification
On every cycle, the assertions check chip-select pulse exclusivity, the holding of an offered command byte, the one-cycle done pulse, and the refusal of requests while busy. They also check that a failing status read keeps the poll in its read loop and that the address cursor steps by one per data byte. The full byte order can only be shown by the bench scenarios, which compare every event against a stream computed from the requests and a behavioural flash. That order covers the header, the page restarts at the right addresses, the number of status reads under delayed busy and write-enable responses, and the wrap at the top of the address space.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] DUMMY    = 8'h00;
  localparam int unsigned ADDR_W  = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_WE_CS, S_WE_OP, S_WE_REL, S_WE_POLL,
    S_OP_CS, S_OP_HDR, S_DATA, S_OP_REL, S_OP_POLL,
    S_WD_CS, S_WD_OP, S_WD_REL, S_WD_POLL, S_DONE
  } seq_state_e;

  typedef enum logic [2:0] {P_IDLE, P_CS, P_OP, P_RD, P_REL} poll_state_e;
endpackage

// File: rtl/fseq_poll.sv
module fseq_poll
  import fseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] mask_i,
  input  logic [7:0] target_i,
  input  logic       xfer_ready_i,
  input  logic [7:0] xfer_rdata_i,
  output logic       idle_o,
  output logic       done_o,
  output logic       cs_assert_o,
  output logic       cs_release_o,
  output logic       xfer_valid_o,
  output logic [7:0] xfer_data_o
);
  poll_state_e p_q, p_d;
  logic hit;

  assign hit = (xfer_rdata_i & mask_i) == target_i;

  always_comb begin
    p_d = p_q;
    unique case (p_q)
      P_IDLE: if (start_i) p_d = P_CS;
      P_CS:   p_d = P_OP;
      P_OP:   if (xfer_ready_i) p_d = P_RD;
      P_RD:   if (xfer_ready_i && hit) p_d = P_REL;
      P_REL:  p_d = P_IDLE;
      default: p_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) p_q <= P_IDLE;
    else         p_q <= p_d;

  assign idle_o       = p_q == P_IDLE;
  assign done_o       = p_q == P_REL;
  assign cs_assert_o  = p_q == P_CS;
  assign cs_release_o = p_q == P_REL;
  assign xfer_valid_o = (p_q == P_OP) || (p_q == P_RD);
  assign xfer_data_o  = (p_q == P_OP) ? OP_RDSR : DUMMY;

  // R11: a non-matching status read keeps the poll reading
  a_r11_keep_polling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_q == P_RD && xfer_ready_i && !hit) |=> (p_q == P_RD));
  // R11: release only follows a status read
  a_r11_release_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_q == P_REL) |-> ($past(p_q) == P_RD));
endmodule

// File: rtl/fseq_cursor.sv
module fseq_cursor #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              empty_o,
  output logic              last_byte_o,
  output logic              page_end_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      rem_q  <= len_i;
    end else if (step_i) begin
      addr_q <= addr_q + ADDR_W'(1);
      rem_q  <= rem_q - LEN_W'(1);
    end

  assign addr_o      = addr_q;
  assign empty_o     = rem_q == '0;
  assign last_byte_o = rem_q == LEN_W'(1);
  assign page_end_o  = &addr_q[PAGE_W-1:0];

  // R6: no byte is consumed beyond the requested count
  a_r6_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !empty_o);
  // R7: address advances by one per data byte, wrapping at the top
  a_r7_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_o == $past(addr_o) + ADDR_W'(1)));
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned PAGE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_erase_i,
  input  logic [23:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             wdata_valid_i,
  output logic             wdata_ready_o,
  input  logic [7:0]       wdata_i,
  output logic             cs_assert_o,
  output logic             cs_release_o,
  output logic             xfer_valid_o,
  input  logic             xfer_ready_i,
  output logic [7:0]       xfer_data_o,
  input  logic [7:0]       xfer_rdata_i,
  output logic             done_o
);
  localparam logic [7:0] ST_BUSY = 8'h01;
  localparam logic [7:0] ST_WEL  = 8'h02;

  seq_state_e state_q, state_d;
  logic       erase_q;
  logic [1:0] hdr_idx_q;

  logic              in_poll, poll_start, poll_idle, poll_done;
  logic              poll_csa, poll_csr, poll_xv;
  logic [7:0]        poll_xd, poll_mask, poll_target;
  logic              cur_load, cur_step, cur_empty, cur_last, cur_page_end;
  logic [ADDR_W-1:0] cur_addr;
  logic              fire;
  logic [7:0]        hdr_byte;

  assign in_poll    = (state_q == S_WE_POLL) || (state_q == S_OP_POLL) || (state_q == S_WD_POLL);
  assign poll_start = in_poll && poll_idle;

  always_comb begin
    unique case (state_q)
      S_WE_POLL: begin poll_mask = ST_BUSY | ST_WEL; poll_target = ST_WEL; end
      S_OP_POLL: begin poll_mask = ST_BUSY;          poll_target = 8'h00;  end
      default:   begin poll_mask = ST_BUSY | ST_WEL; poll_target = 8'h00;  end
    endcase
  end

  fseq_poll u_poll (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (poll_start),
    .mask_i       (poll_mask),
    .target_i     (poll_target),
    .xfer_ready_i (xfer_ready_i),
    .xfer_rdata_i (xfer_rdata_i),
    .idle_o       (poll_idle),
    .done_o       (poll_done),
    .cs_assert_o  (poll_csa),
    .cs_release_o (poll_csr),
    .xfer_valid_o (poll_xv),
    .xfer_data_o  (poll_xd)
  );

  assign cur_load = (state_q == S_IDLE) && req_valid_i;
  assign cur_step = (state_q == S_DATA) && fire;

  fseq_cursor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_cursor (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cur_load),
    .addr_i      (req_addr_i),
    .len_i       (req_erase_i ? '0 : req_len_i),
    .step_i      (cur_step),
    .addr_o      (cur_addr),
    .empty_o     (cur_empty),
    .last_byte_o (cur_last),
    .page_end_o  (cur_page_end)
  );

  always_comb begin
    unique case (hdr_idx_q)
      2'd0:    hdr_byte = erase_q ? OP_ERASE : OP_PROG;
      2'd1:    hdr_byte = cur_addr[23:16];
      2'd2:    hdr_byte = cur_addr[15:8];
      default: hdr_byte = cur_addr[7:0];
    endcase
  end

  always_comb begin
    cs_assert_o   = 1'b0;
    cs_release_o  = 1'b0;
    xfer_valid_o  = 1'b0;
    xfer_data_o   = DUMMY;
    wdata_ready_o = 1'b0;
    unique case (state_q)
      S_WE_CS, S_OP_CS, S_WD_CS:    cs_assert_o = 1'b1;
      S_WE_REL, S_OP_REL, S_WD_REL: cs_release_o = 1'b1;
      S_WE_OP: begin xfer_valid_o = 1'b1; xfer_data_o = OP_WREN; end
      S_WD_OP: begin xfer_valid_o = 1'b1; xfer_data_o = OP_WRDI; end
      S_OP_HDR: begin xfer_valid_o = 1'b1; xfer_data_o = hdr_byte; end
      S_DATA: begin
        xfer_valid_o  = wdata_valid_i;
        xfer_data_o   = wdata_i;
        wdata_ready_o = xfer_ready_i;
      end
      S_WE_POLL, S_OP_POLL, S_WD_POLL: begin
        cs_assert_o  = poll_csa;
        cs_release_o = poll_csr;
        xfer_valid_o = poll_xv;
        xfer_data_o  = poll_xd;
      end
      default: ;
    endcase
  end

  assign fire        = xfer_valid_o && xfer_ready_i;
  assign req_ready_o = state_q == S_IDLE;
  assign done_o      = state_q == S_DONE;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (req_valid_i) state_d = S_WE_CS;
      S_WE_CS:   state_d = S_WE_OP;
      S_WE_OP:   if (fire) state_d = S_WE_REL;
      S_WE_REL:  state_d = S_WE_POLL;
      S_WE_POLL: if (poll_done) state_d = S_OP_CS;
      S_OP_CS:   state_d = S_OP_HDR;
      S_OP_HDR:  if (fire && hdr_idx_q == 2'd3)
                   state_d = (erase_q || cur_empty) ? S_OP_REL : S_DATA;
      S_DATA:    if (fire && (cur_last || cur_page_end)) state_d = S_OP_REL;
      S_OP_REL:  state_d = S_OP_POLL;
      S_OP_POLL: if (poll_done) state_d = cur_empty ? S_WD_CS : S_WE_CS;
      S_WD_CS:   state_d = S_WD_OP;
      S_WD_OP:   if (fire) state_d = S_WD_REL;
      S_WD_REL:  state_d = S_WD_POLL;
      S_WD_POLL: if (poll_done) state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      erase_q   <= 1'b0;
      hdr_idx_q <= '0;
    end else begin
      state_q <= state_d;
      if (cur_load) erase_q <= req_erase_i;
      if (state_q == S_OP_CS)                hdr_idx_q <= '0;
      else if (state_q == S_OP_HDR && fire)  hdr_idx_q <= hdr_idx_q + 2'd1;
    end

  // R12: chip-select pulses are exclusive with each other and with transfers
  a_r12_cs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_assert_o || cs_release_o) |-> !(xfer_valid_o || (cs_assert_o && cs_release_o)));
  // R12: an offered command, address or poll byte holds until taken
  a_r12_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && !xfer_ready_i && state_q != S_DATA) |=> (xfer_valid_o && $stable(xfer_data_o)));
  // R10: done is a single pulse followed by ready
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));
  // R2: after acceptance the block refuses further requests
  a_r2_busy_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R6: a taken data byte is the byte transferred
  a_r6_data_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdata_valid_i && wdata_ready_o) |-> (fire && xfer_data_o == wdata_i && !req_ready_o));
endmodule

// File: tb/sim_fseq_ctrl.sv
module sim_fseq_ctrl;
  localparam int LEN_W = 12;
  localparam int EV_CSA = 256, EV_CSR = 512, EV_DONE = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_erase = 1'b0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic wdata_valid = 1'b0, xfer_ready = 1'b0;
  logic [7:0] wdata = '0, xfer_rdata = '0;
  logic req_ready, wdata_ready, cs_assert, cs_release, xfer_valid, done;
  logic [7:0] xfer_data;

  always #4 clk = ~clk;

  fseq_ctrl #(.LEN_W(LEN_W), .PAGE_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_erase_i(req_erase),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .wdata_valid_i(wdata_valid), .wdata_ready_o(wdata_ready), .wdata_i(wdata),
    .cs_assert_o(cs_assert), .cs_release_o(cs_release),
    .xfer_valid_o(xfer_valid), .xfer_ready_i(xfer_ready),
    .xfer_data_o(xfer_data), .xfer_rdata_i(xfer_rdata), .done_o(done));

  int errors = 0, checks = 0;
  int exp_q[$];
  logic [7:0] data_q[$];
  string cur_tag = "R1";

  // behavioural flash
  bit cs_m = 0, wel_m = 0;
  int tr_idx = 0, tr_op = 0, busy_left = 0, lag_left = 0;
  int cfg_busy = 0, cfg_lag = 0, consumed = 0;
  bit stall = 0, done_seen = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_now();
    return {6'b0, wel_m && (lag_left == 0), busy_left > 0};
  endfunction

  function automatic void push_poll(input int reads);
    exp_q.push_back(EV_CSA); exp_q.push_back(8'h05);
    for (int i = 0; i < reads; i++) exp_q.push_back(8'h00);
    exp_q.push_back(EV_CSR);
  endfunction

  function automatic void push_wren();
    exp_q.push_back(EV_CSA); exp_q.push_back(8'h06); exp_q.push_back(EV_CSR);
    push_poll(cfg_lag + 1);
  endfunction

  function automatic void push_hdr(input int cmd, input int a);
    exp_q.push_back(EV_CSA); exp_q.push_back(cmd);
    exp_q.push_back((a >> 16) & 255); exp_q.push_back((a >> 8) & 255); exp_q.push_back(a & 255);
  endfunction

  function automatic void gen_expected(input bit erase, input int addr, input int len);
    int a = addr;
    push_wren();
    push_hdr(erase ? 8'h20 : 8'h02, a);
    if (!erase) begin
      for (int i = 0; i < len; i++) begin
        exp_q.push_back(data_q[i]);
        a = (a + 1) & 24'hFFFFFF;
        if (i == len - 1) break;
        if ((a & 255) == 0) begin
          exp_q.push_back(EV_CSR);
          push_poll(cfg_busy + 1);
          push_wren();
          push_hdr(8'h02, a);
        end
      end
    end
    exp_q.push_back(EV_CSR);
    push_poll(cfg_busy + 1);
    exp_q.push_back(EV_CSA); exp_q.push_back(8'h04); exp_q.push_back(EV_CSR);
    push_poll(1);
    exp_q.push_back(EV_DONE);
  endfunction

  task automatic event_seen(input int ev);
    if (exp_q.size() == 0) check(1'b0, cur_tag, ev, -1);
    else begin
      check(exp_q[0] == ev, cur_tag, ev, exp_q[0]);
      void'(exp_q.pop_front());
    end
  endtask

  // drive at falling edge, sample just before rising edge, compare every clock
  initial forever begin
    @(negedge clk);
    xfer_ready  = stall ? lfsr[0] : 1'b1;
    wdata_valid = (data_q.size() > 0) && (stall ? lfsr[3] : 1'b1);
    wdata       = (data_q.size() > 0) ? data_q[0] : 8'h00;
    xfer_rdata  = (cs_m && tr_op == 5 && tr_idx >= 1) ? status_now() : 8'hA5;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #3;
    if (rst_n) begin
      if ((cs_assert || cs_release) && xfer_valid)
        check(1'b0, "R12", 1, 0);
      if (cs_assert) begin
        event_seen(EV_CSA);
        cs_m = 1; tr_idx = 0; tr_op = -1;
      end
      if (cs_release) begin
        event_seen(EV_CSR);
        if (tr_op == 6) begin wel_m = 1; lag_left = cfg_lag; end
        if (tr_op == 4) wel_m = 0;
        if ((tr_op == 2 || tr_op == 32) && tr_idx >= 4) begin busy_left = cfg_busy; wel_m = 0; end
        cs_m = 0;
      end
      if (xfer_valid && xfer_ready) begin
        if (!cs_m) check(1'b0, "R12", 0, 1);
        event_seen(int'(xfer_data));
        if (tr_idx == 0) tr_op = int'(xfer_data);
        else if (tr_op == 5) begin
          if (lag_left > 0) lag_left--;
          if (busy_left > 0) busy_left--;
        end
        tr_idx++;
      end
      if (wdata_valid && wdata_ready) begin
        void'(data_q.pop_front());
        consumed++;
      end
      if (done) begin
        event_seen(EV_DONE);
        done_seen = 1;
      end
    end
  end

  task automatic run_op(input bit erase, input int addr, input int len, input int busy,
                        input int lag, input bit stl, input bit spurious, input string tag);
    int cyc = 0;
    cur_tag = tag; cfg_busy = busy; cfg_lag = lag; stall = stl;
    consumed = 0; done_seen = 0;
    if (!erase) for (int i = 0; i < len; i++) data_q.push_back(8'((addr + i * 7 + len) & 255));
    gen_expected(erase, addr, len);
    @(negedge clk);
    req_valid = 1; req_erase = erase; req_addr = 24'(addr); req_len = LEN_W'(erase ? 5 : len);
    @(negedge clk);
    req_valid = 0;
    if (spurious) begin
      // R2: a request offered while busy must be refused and leave the stream unchanged
      for (int i = 0; i < 20; i++) begin
        req_valid = 1; req_erase = 1; req_addr = 24'h777000; req_len = 9;
        @(negedge clk);
        check(req_ready == 1'b0, "R2", req_ready, 0);
      end
      req_valid = 0;
    end
    while (!done_seen && cyc < 20000) begin @(negedge clk); cyc++; end
    if (!done_seen) begin
      check(1'b0, {tag, " watchdog"}, cyc, 20000);
      exp_q.delete(); data_q.delete();
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R10", req_ready, 1);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    if (erase) check(consumed == 0, "R5", consumed, 0);
    else       check(consumed == len, "R6", consumed, len);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle outputs during and after reset
    check(req_ready == 1'b1 && done == 1'b0, "R1", {req_ready, done}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && !done && !xfer_valid && !cs_assert && !cs_release, "R1",
          {req_ready, done, xfer_valid, cs_assert, cs_release}, 16);
    // R5 R3 R8 R9 R11: erase with delayed write-enable latch and long busy
    run_op(1, 24'h0AB000, 0, 4, 2, 0, 0, "R5");
    // R4 R6: short program, no stalls
    run_op(0, 24'h001020, 5, 1, 0, 0, 0, "R4");
    // R7: program crossing one page boundary with random stalls
    run_op(0, 24'h0000FC, 10, 2, 1, 1, 0, "R7");
    // R7 R2: long program crossing two boundaries, busy request overlay
    run_op(0, 24'h0001F0, 300, 3, 0, 1, 1, "R7");
    // R7: last byte at page offset 0xFF, no restart
    run_op(0, 24'h0000F0, 16, 0, 0, 0, 0, "R7");
    // R13: zero-length program
    run_op(0, 24'h123456, 0, 2, 0, 0, 0, "R13");
    // R7: boundary at the top of the address space wraps to zero
    run_op(0, 24'hFFFFFE, 4, 1, 3, 1, 0, "R7");
    // R9 R11: erase under stalls
    run_op(1, 24'h3FF000, 0, 6, 4, 1, 0, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule